// File: doc/BRIEF.md
# Two-Entry Prefetch and Conditional Issue Unit

This block sits at the front of a simple in-order core. It holds two instruction words fetched ahead of execution and a program counter that moves one 32-bit word per step. Each accepted step issues the word at the head of the queue. The second word then moves to the head, and the word loaded from memory fills the vacated second entry. The block presents the address of the next word that a step will load. Memory answers that address with a data word and a valid flag in the same cycle.

For each issued word the unit checks the 4-bit condition code in the top nibble against the current N, Z, C and V flags. It reports whether the instruction executes. When the condition fails, it reports a fixed count of skipped cycles instead. It also forms a 12-bit dispatch index from two opcode fields, which the execute stage uses to look up a handler.

A separate port pushes an externally supplied opcode in front of the queue and rolls the program counter back by one word. This lets a debugger or exception sequencer run one extra instruction. Execution of instructions is handled elsewhere.

Top module: `fetch_issue_unit`

## Requirements
- R1: After synchronous reset, `fetch_addr_o` equals RESET_PC+4 (4 by default), and `issue_fire_o`, `exec_o` and `skip_cycles_o` are 0. Both queue entries hold 0.
- R2: A step is accepted when `step_i` and `fetch_valid_i` are both 1 and `inject_i` is 0. An accepted step raises `issue_fire_o` one cycle later and increases `fetch_addr_o` by 4 at the same edge.
- R3: Words issue in fetch order. On an accepted step the head issues and the second entry becomes the head. The word on `fetch_data_i` (read from `fetch_addr_o`) becomes the second entry. A word is therefore issued two steps after it was loaded.
- R4: A step with `fetch_valid_i` at 0 is ignored. `fetch_addr_o` holds, `issue_fire_o` stays 0, and the queue order is unchanged.
- R5: Condition code 0xE (bits 31:28) always executes, whatever the flags.
- R6: Condition codes 0x0 to 0xD test the flags `flags_i` = {N,Z,C,V} (bit 3 = N, bit 0 = V) as follows: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; A N==V; B N!=V; C !Z&(N==V); D Z|(N!=V). The flags sampled are those present in the cycle of the accepted step.
- R7: Condition code 0xF never executes.
- R8: An issued word whose condition fails gives `exec_o`=0 and `skip_cycles_o`=SKIP_PENALTY (2 by default). An executing word gives `skip_cycles_o`=0. `exec_o` and `skip_cycles_o` are 0 in cycles without an issue.
- R9: On issue, `dispatch_idx_o` equals {op[27:20], op[7:4]}, and `issue_op_o` equals the issued word.
- R10: An inject decreases `fetch_addr_o` by 4 and moves the current head into the second entry. It places `inject_op_i` at the head, so the next accepted step issues the injected word and the step after that issues the former head.
- R11: When `inject_i` and `step_i` are both 1 in one cycle, only the inject takes effect. No word issues in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| fetch_data_i | input | 32 | Memory word at `fetch_addr_o` |
| fetch_valid_i | input | 1 | `fetch_data_i` is valid this cycle |
| step_i | input | 1 | Request to issue the head word |
| inject_i | input | 1 | Push `inject_op_i` to the head |
| inject_op_i | input | 32 | Opcode to inject |
| fetch_addr_o | output | 32 | Address the next step loads from |
| issue_fire_o | output | 1 | A word was issued (registered) |
| issue_op_o | output | 32 | Last issued word |
| exec_o | output | 1 | Issued word's condition passed |
| dispatch_idx_o | output | 12 | Handler index of the issued word |
| skip_cycles_o | output | 4 | Skip penalty for a failed condition |

## Verification
`fetch_addr_o` is derived directly from the program counter. It therefore takes its new value at the same rising edge that accepts a step or inject. The issue outputs (`issue_fire_o`, `issue_op_o`, `exec_o`, `dispatch_idx_o`, `skip_cycles_o`) carry one register stage, so they are due at the edge after the accepting one. They reflect the flags and queue head present in the accepting cycle. The bench drives each stimulus at a falling edge and updates its reference queue and program counter for that stimulus. It then waits through exactly one rising edge and compares every output at the next falling edge, so each prediction lines up with the edge that produces it.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
    localparam int OP_W   = 32;
    localparam int ADDR_W = 32;
    localparam int CC_W   = 4;
    localparam int IDX_HI = 8;
    localparam int IDX_LO = 4;
    localparam int IDX_W  = IDX_HI + IDX_LO;
    localparam int NUM_CC = 1 << CC_W;

    typedef logic [OP_W-1:0]   op_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [CC_W-1:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cc_e;

    function automatic logic cc_pass(cc_e cc, flags_t f);
        logic r;
        case (cc)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] disp_index(op_t op);
        return {op[27:20], op[7:4]};
    endfunction
endpackage

// File: rtl/fiu_queue.sv
module fiu_queue
    import fiu_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step_i,
    input  logic  fetch_ok_i,
    input  logic  inject_i,
    input  op_t   inject_op_i,
    input  op_t   fetch_word_i,
    output op_t   head_o,
    output addr_t fetch_addr_o,
    output logic  advance_o
);
    localparam int    WORD_BYTES = OP_W / 8;
    localparam addr_t PC_STEP    = addr_t'(WORD_BYTES);

    addr_t pc_q;
    op_t   head_q;
    op_t   second_q;

    assign advance_o    = step_i && fetch_ok_i && !inject_i;
    assign fetch_addr_o = pc_q + PC_STEP;
    assign head_o       = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            head_q   <= '0;
            second_q <= '0;
        end else if (inject_i) begin
            pc_q     <= pc_q - PC_STEP;
            second_q <= head_q;
            head_q   <= inject_op_i;
        end else if (advance_o) begin
            pc_q     <= pc_q + PC_STEP;
            head_q   <= second_q;
            second_q <= fetch_word_i;
        end
    end

    // R2
    pc_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && fetch_ok_i && !inject_i) |=> (pc_q == $past(pc_q) + PC_STEP));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_ok_i && !inject_i) |=> ($stable(pc_q) && $stable(head_q) && $stable(second_q)));

    // R10
    inject_head_chk: assert property (@(posedge clk) disable iff (rst)
        inject_i |=> (head_q == $past(inject_op_i) && second_q == $past(head_q)));

    // R11
    inject_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (inject_i && step_i) |=> (pc_q == $past(pc_q) - PC_STEP));
endmodule

// File: rtl/fiu_cond.sv
module fiu_cond
    import fiu_pkg::*;
(
    input  logic [CC_W-1:0] cc_i,
    input  flags_t          flags_i,
    output logic            pass_o
);
    logic [NUM_CC-1:0] pass_vec;

    for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
        assign pass_vec[k] = cc_pass(cc_e'(CC_W'(k)), flags_i);
    end

    assign pass_o = pass_vec[cc_i];

    // R5
    always_comb begin
        always_chk: assert (!(cc_i == CC_AL) || pass_o);
    end
endmodule

// File: rtl/fiu_issue_reg.sv
module fiu_issue_reg
    import fiu_pkg::*;
#(
    parameter int SKIP_W       = 4,
    parameter int SKIP_PENALTY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic              pass_i,
    input  op_t               op_i,
    output logic              fire_o,
    output logic              exec_o,
    output op_t               op_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [SKIP_W-1:0] skip_o
);
    localparam logic [SKIP_W-1:0] PENALTY = SKIP_W'(SKIP_PENALTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_o <= 1'b0;
            exec_o <= 1'b0;
            skip_o <= '0;
            op_o   <= '0;
            idx_o  <= '0;
        end else begin
            fire_o <= fire_i;
            exec_o <= fire_i && pass_i;
            skip_o <= (fire_i && !pass_i) ? PENALTY : '0;
            if (fire_i) begin
                op_o  <= op_i;
                idx_o <= disp_index(op_i);
            end
        end
    end

    // R7
    never_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_o && op_o[31:28] == CC_NV) |-> !exec_o);

    // R5
    always_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_o && op_o[31:28] == CC_AL) |-> exec_o);

    // R8
    skip_penalty_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_o && !exec_o) |-> (skip_o == PENALTY));

    // R8
    no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_o || !fire_o) |-> (skip_o == '0));
endmodule

// File: rtl/fetch_issue_unit.sv
module fetch_issue_unit
    import fiu_pkg::*;
#(
    parameter logic [31:0] RESET_PC     = 32'h0,
    parameter int          SKIP_W       = 4,
    parameter int          SKIP_PENALTY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        flags_i,
    input  logic [31:0]       fetch_data_i,
    input  logic              fetch_valid_i,
    input  logic              step_i,
    input  logic              inject_i,
    input  logic [31:0]       inject_op_i,
    output logic [31:0]       fetch_addr_o,
    output logic              issue_fire_o,
    output logic [31:0]       issue_op_o,
    output logic              exec_o,
    output logic [11:0]       dispatch_idx_o,
    output logic [SKIP_W-1:0] skip_cycles_o
);
    op_t  head;
    logic advance;
    logic pass;

    fiu_queue #(.RESET_PC(RESET_PC)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .step_i       (step_i),
        .fetch_ok_i   (fetch_valid_i),
        .inject_i     (inject_i),
        .inject_op_i  (inject_op_i),
        .fetch_word_i (fetch_data_i),
        .head_o       (head),
        .fetch_addr_o (fetch_addr_o),
        .advance_o    (advance)
    );

    fiu_cond u_cond (
        .cc_i    (head[31:28]),
        .flags_i (flags_t'(flags_i)),
        .pass_o  (pass)
    );

    fiu_issue_reg #(.SKIP_W(SKIP_W), .SKIP_PENALTY(SKIP_PENALTY)) u_issue (
        .clk    (clk),
        .rst    (rst),
        .fire_i (advance),
        .pass_i (pass),
        .op_i   (head),
        .fire_o (issue_fire_o),
        .exec_o (exec_o),
        .op_o   (issue_op_o),
        .idx_o  (dispatch_idx_o),
        .skip_o (skip_cycles_o)
    );
endmodule

// File: tb/fetch_issue_unit_tb.sv
module fetch_issue_unit_tb;
    localparam int SKIP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  flags = '0;
    logic [31:0] fdata;
    logic        fvalid = 1'b0;
    logic        step = 1'b0;
    logic        inj = 1'b0;
    logic [31:0] inj_op = '0;
    logic [31:0] faddr;
    logic        fire;
    logic [31:0] iop;
    logic        ex;
    logic [11:0] idx;
    logic [3:0]  skip;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ (a >> 7) ^ 32'h5BD1E995;
    endfunction

    assign fdata = mem_word(faddr);

    fetch_issue_unit u_dut (
        .clk(clk), .rst(rst), .flags_i(flags), .fetch_data_i(fdata),
        .fetch_valid_i(fvalid), .step_i(step), .inject_i(inj),
        .inject_op_i(inj_op), .fetch_addr_o(faddr), .issue_fire_o(fire),
        .issue_op_o(iop), .exec_o(ex), .dispatch_idx_o(idx),
        .skip_cycles_o(skip)
    );

    function automatic bit tb_pass(logic [3:0] c, logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        if (c == 4'hE) return 1'b1;
        if (c == 4'hF) return 1'b0;
        if (c == 4'h0) return z;
        if (c == 4'h1) return !z;
        if (c == 4'h2) return cy;
        if (c == 4'h3) return !cy;
        if (c == 4'h4) return n;
        if (c == 4'h5) return !n;
        if (c == 4'h6) return v;
        if (c == 4'h7) return !v;
        if (c == 4'h8) return cy & !z;
        if (c == 4'h9) return !cy | z;
        if (c == 4'hA) return n == v;
        if (c == 4'hB) return n != v;
        if (c == 4'hC) return !z & (n == v);
        return z | (n != v);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // reference model
    logic [31:0] m_pc = 32'h0;
    logic [31:0] m_q0 = '0, m_q1 = '0;
    bit          m_i0 = 0, m_i1 = 0;

    task automatic run_cycle(bit st, bit vl, bit ij, logic [31:0] op, logic [3:0] fl);
        bit          acc;
        bit          e_fire, e_exec, from_inj;
        logic [31:0] e_op;
        logic [3:0]  e_skip;
        string       atag, ftag, xtag;
        step = st; fvalid = vl; inj = ij; inj_op = op; flags = fl;
        acc = st && vl && !ij;
        e_fire = acc;
        e_op = m_q0;
        from_inj = m_i0;
        e_exec = acc && tb_pass(m_q0[31:28], fl);
        e_skip = (acc && !e_exec) ? 4'(SKIP) : 4'd0;
        xtag = (m_q0[31:28] == 4'hE) ? "R5" : (m_q0[31:28] == 4'hF) ? "R7" : "R6";
        ftag = (ij && st) ? "R11" : (st && !vl) ? "R4" : "R2";
        atag = (ij && st) ? "R11" : ij ? "R10" : (st && !vl) ? "R4" : "R2";
        if (ij) begin
            m_pc = m_pc - 4; m_q1 = m_q0; m_i1 = m_i0; m_q0 = op; m_i0 = 1;
        end else if (acc) begin
            m_q0 = m_q1; m_i0 = m_i1; m_q1 = mem_word(m_pc + 4); m_i1 = 0;
            m_pc = m_pc + 4;
        end
        @(posedge clk);
        @(negedge clk);
        chk({atag, " fetch_addr"}, faddr, m_pc + 4);
        chk({ftag, " issue_fire"}, 32'(fire), 32'(e_fire));
        chk({xtag, " exec"}, 32'(ex), 32'(e_exec));
        chk("R8 skip_cycles", 32'(skip), 32'(e_skip));
        if (e_fire) begin
            chk(from_inj ? "R10 issued op" : "R3 issued op", iop, e_op);
            chk("R9 dispatch_idx", 32'(idx), 32'({e_op[27:20], e_op[7:4]}));
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 fetch_addr", faddr, 32'h4);
        chk("R1 issue_fire", 32'(fire), 0);
        chk("R1 exec", 32'(ex), 0);
        chk("R1 skip", 32'(skip), 0);
        rst = 1'b0;
        // R1: first two issues are the zeroed queue entries
        run_cycle(1, 1, 0, 0, 4'b0100);
        run_cycle(1, 1, 0, 0, 4'b0000);
        // R4 directed stall
        run_cycle(1, 0, 0, 0, 4'h0);
        run_cycle(1, 0, 0, 0, 4'hF);
        run_cycle(1, 1, 0, 0, 4'h3);
        // R10 directed inject, then two steps
        run_cycle(0, 1, 1, 32'hE12A_3B4C, 4'h0);
        run_cycle(1, 1, 0, 0, 4'h0);
        run_cycle(1, 1, 0, 0, 4'h0);
        // R11 inject with step in same cycle
        run_cycle(1, 1, 1, 32'hF0F0_0F0F, 4'hA);
        run_cycle(1, 1, 0, 0, 4'hA);
        // R5 R6 R7 every condition code against every flag pattern
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                run_cycle(0, 0, 1, {4'(c), 28'($urandom)}, 4'h0);
                run_cycle(1, 1, 0, 0, 4'(f));
            end
        end
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            run_cycle(($urandom % 10) < 7, ($urandom % 10) < 8,
                      ($urandom % 100) < 8, $urandom, 4'($urandom));
        end
        summary();
    end
endmodule